// File: doc/BRIEF.md
# SONET A1A2 Frame Aligner

This block sits behind a 1:4 deserializer on a SONET/SDH receive path. Each clock it takes one 4-bit word of the serial stream, in which bit 0 is the earliest bit on the line. It watches every bit position of that stream for the framing word: three A1 bytes followed directly by one A2 byte. When it finds the word, it takes that bit position as the byte boundary. It then hands out 4-bit words that are realigned to that boundary.

Finding the word once does not put the block in sync. It needs the word three times in a row, at the same bit position, each exactly one frame period after the one before. When that happens it drives a frame-sync pulse that lasts four clocks. Once in sync, the block follows only the expected frame position, so a copy of the framing word inside the payload cannot move the boundary. If the word is missing at the expected position for several frames in a row, the block goes back to searching.

A search enable lets the surrounding logic stop the search. While the enable is low, the boundary and all framing state stay as they are. The frame period is a parameter counted in word clocks.

Top module: `sonet_frame_align`

## Requirements
- R1: While reset is held and on the first cycle after it, `aln_nib` is 0 and `frame_sync` is 0, and the block is searching.
- R2: `rx_nib[0]` is the earliest bit of each input word and `aln_nib[0]` is the earliest bit of each output word. At boundary offset k (0 to 3), the output word holds the four consecutive stream bits that end k bits before the newest input bit. The output is registered, so with k = 0 a word driven before clock edge n appears after edge n+1.
- R3: The framing word is the 32-bit sequence F6 F6 F6 28 (hex), with the most significant bit of each byte first in time. It is recognised at any of the 4 bit offsets. If it matches at more than one offset, the lowest offset is taken.
- R4: While searching, a match with search enabled sets the boundary offset, starts a frame-period count and sets the confirmation count to one.
- R5: The block declares sync when the third framing word arrives at the same offset, each word exactly `FRAME_NIBBLES` clocks after the one before. `frame_sync` goes high on the cycle after the clock that detects the third word and stays high for exactly 4 cycles. It is never high before the third word.
- R6: While confirming, a framing word at another offset, or at a time other than the expected one, restarts the confirmation at one from that word. If no framing word arrives at the expected time, the block returns to searching.
- R7: In sync, framing words anywhere other than the expected position and offset are ignored: the offset does not change and `frame_sync` stays low.
- R8: In sync, 4 consecutive frames without the framing word at the expected position return the block to searching. A framing word found at that position clears the miss count.
- R9: While `frame_en` is low, the offset, the framing state and all counters hold their values, and no sync is declared. Data keeps flowing through the frozen offset.
- R10: `frame_sync` pulses only on entry into sync and never while sync is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_en | input | 1 | Search enable; low freezes the alignment |
| rx_nib | input | DW | Deserialized input word, bit 0 earliest |
| aln_nib | output | DW | Realigned output word, bit 0 earliest |
| frame_sync | output | 1 | Four-cycle pulse when sync is declared |

## Verification
The bench builds the block with `FRAME_NIBBLES` set to 40, a frame of 160 bits, and keeps the confirmation count, miss limit and pulse length at their defaults. With that short frame, a single run can cover:
- acquiring sync;
- copies of the framing word inside the payload;
- freezing the search while the stream slips by two bits;
- recovering through four missed frames;
- restarting confirmation after a slip.

The full default frame would take tens of thousands of clocks per frame, so these cases would be out of reach with it.

// File: rtl/sfa_pkg.sv
// Shared types and constants for the frame aligner.
package sfa_pkg;
    // Framing state: searching, confirming a candidate, or in sync.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_SYNC    = 2'd2
    } sfa_state_e;

    // Three A1 bytes then one A2 byte, first bit in time at the MSB.
    localparam int          PAT_W   = 32;
    localparam logic [31:0] PAT_SEQ = 32'hF6F6_F628;
endpackage

// File: rtl/sfa_shift.sv
// Bit-history shifter and pattern matcher.
// Keeps the serial stream history (newest bit at index 0), flags
// the framing word at each of DW bit offsets and outputs the
// DW-bit word selected by the current offset, registered.
// Assumes din[0] is the earliest bit of each input word.
module sfa_shift
    import sfa_pkg::*;
#(
    parameter int DW    = 4,
    parameter int OFF_W = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    din,
    input  logic [OFF_W-1:0] off,
    output logic [DW-1:0]    match,
    output logic [DW-1:0]    dout
);
    localparam int HIST_W = PAT_W + DW - 1;

    logic [HIST_W-1:0] hist;
    logic [DW-1:0]     din_rev;
    logic [DW-1:0]     win;

    // Reverse the word so the latest bit lands at the history LSB.
    always_comb begin
        for (int i = 0; i < DW; i++) din_rev[i] = din[DW-1-i];
    end

    // Shift the stream history by one word per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HIST_W-DW-1:0], din_rev};
    end

    // One comparator per bit offset.
    for (genvar k = 0; k < DW; k++) begin : g_cmp
        assign match[k] = (hist[k+PAT_W-1:k] == PAT_SEQ);
    end

    // Pick the aligned word; output bit 0 is the oldest bit.
    always_comb begin
        for (int i = 0; i < DW; i++) win[i] = hist[int'(off) + DW - 1 - i];
    end

    // Register the aligned word.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= win;
    end
endmodule

// File: rtl/sfa_fsm.sv
// Framing state machine.
// Searches for a candidate, confirms it at frame spacing, holds
// sync and counts missed frames. All updates hold while en is low.
// Assumes match[] is valid in the cycle after the pattern arrives.
module sfa_fsm
    import sfa_pkg::*;
#(
    parameter int DW        = 4,
    parameter int OFF_W     = (DW > 1) ? $clog2(DW) : 1,
    parameter int FRAME     = 77760,
    parameter int CONFIRM_N = 3,
    parameter int MISS_N    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DW-1:0]    match,
    output logic [OFF_W-1:0] off,
    output sfa_state_e       state,
    output logic             sync_set
);
    localparam int FC_W   = (FRAME > 1) ? $clog2(FRAME) : 1;
    localparam int CNT_W  = $clog2(CONFIRM_N + 1);
    localparam int MISS_W = $clog2(MISS_N + 1);

    logic [FC_W-1:0]   fcnt, fcnt_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [MISS_W-1:0] miss, miss_n;
    logic [OFF_W-1:0]  off_n, lo;
    sfa_state_e        state_n;
    logic              any, at_exp, hit;

    // Lowest matching offset wins.
    always_comb begin
        lo = '0;
        for (int k = DW - 1; k >= 0; k--) if (match[k]) lo = OFF_W'(k);
    end

    assign any    = |match;
    assign at_exp = (fcnt == FC_W'(FRAME - 1));
    assign hit    = match[off];

    // Next-state and counter logic.
    always_comb begin
        state_n  = state;
        off_n    = off;
        cnt_n    = cnt;
        miss_n   = miss;
        fcnt_n   = fcnt;
        sync_set = 1'b0;
        if (en) begin
            unique case (state)
                ST_HUNT: begin
                    fcnt_n = '0;
                    if (any) begin
                        off_n   = lo;
                        cnt_n   = CNT_W'(1);
                        state_n = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (at_exp && hit) begin
                        fcnt_n = '0;
                        if (cnt == CNT_W'(CONFIRM_N - 1)) begin
                            state_n  = ST_SYNC;
                            miss_n   = '0;
                            cnt_n    = '0;
                            sync_set = 1'b1;
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end else if (any) begin
                        off_n  = lo;
                        cnt_n  = CNT_W'(1);
                        fcnt_n = '0;
                    end else if (at_exp) begin
                        state_n = ST_HUNT;
                        cnt_n   = '0;
                        fcnt_n  = '0;
                    end else begin
                        fcnt_n = fcnt + FC_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (at_exp) begin
                        fcnt_n = '0;
                        if (hit) begin
                            miss_n = '0;
                        end else if (miss == MISS_W'(MISS_N - 1)) begin
                            miss_n  = '0;
                            state_n = ST_HUNT;
                        end else begin
                            miss_n = miss + MISS_W'(1);
                        end
                    end else begin
                        fcnt_n = fcnt + FC_W'(1);
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            off   <= '0;
            cnt   <= '0;
            miss  <= '0;
            fcnt  <= '0;
        end else begin
            state <= state_n;
            off   <= off_n;
            cnt   <= cnt_n;
            miss  <= miss_n;
            fcnt  <= fcnt_n;
        end
    end

    // R9: disabled search freezes offset and state.
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(off) && $stable(state)));

    // R7: sync never moves the boundary.
    a_r7_sync_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |=> $stable(off));

    // R6: confirmation count stays between one and the last step.
    a_r6_confirm_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(CONFIRM_N - 1)));

    // R8: sync is left only toward search.
    a_r8_sync_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |=> (state != ST_CONFIRM));
endmodule

// File: rtl/sfa_pulse.sv
// Pulse stretcher: a one-cycle set yields LEN cycles of output,
// starting the cycle after the set.
module sfa_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic pulse
);
    localparam int PC_W = $clog2(LEN + 1);

    logic [PC_W-1:0] pcnt;

    // Load on set, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           pcnt <= '0;
        else if (set)         pcnt <= PC_W'(LEN);
        else if (pcnt != '0)  pcnt <= pcnt - PC_W'(1);
    end

    assign pulse = (pcnt != '0);

    // R5: once started, the pulse keeps going until it is done.
    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && pcnt > PC_W'(1)) |=> pulse);
endmodule

// File: rtl/sonet_frame_align.sv
// SONET/SDH frame aligner top.
// Finds the three-A1 / one-A2 framing word at any bit offset of a
// DW-bit stream, confirms it over CONFIRM_N frames spaced
// FRAME_NIBBLES clocks apart, outputs realigned words and pulses
// frame_sync on entry into sync.
// Assumes rx_nib[0] is the earliest received bit.
module sonet_frame_align
    import sfa_pkg::*;
#(
    parameter int DW            = 4,
    parameter int FRAME_NIBBLES = 77760,
    parameter int CONFIRM_N     = 3,
    parameter int MISS_N        = 4,
    parameter int PULSE_LEN     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_en,
    input  logic [DW-1:0] rx_nib,
    output logic [DW-1:0] aln_nib,
    output logic          frame_sync
);
    localparam int OFF_W = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0]    match;
    logic [OFF_W-1:0] off;
    sfa_state_e       state;
    logic             sync_set;

    sfa_shift #(.DW(DW), .OFF_W(OFF_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_nib),
        .off   (off),
        .match (match),
        .dout  (aln_nib)
    );

    sfa_fsm #(
        .DW(DW), .OFF_W(OFF_W), .FRAME(FRAME_NIBBLES),
        .CONFIRM_N(CONFIRM_N), .MISS_N(MISS_N)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (frame_en),
        .match    (match),
        .off      (off),
        .state    (state),
        .sync_set (sync_set)
    );

    sfa_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sync_set),
        .pulse (frame_sync)
    );

    // R10: the pulse starts only on the clock that entered sync.
    a_r10_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_sync) |-> (state == ST_SYNC && $past(state) == ST_CONFIRM));
endmodule

// File: tb/sonet_frame_align_tb.sv
// Bench: behavioural reference model compared on every clock.
module sonet_frame_align_tb;
    localparam int FRAME = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_en = 1'b1;
    logic [3:0] rx_nib = '0;
    logic [3:0] aln_nib;
    logic       frame_sync;

    always #2.5 clk = ~clk;

    sonet_frame_align #(.FRAME_NIBBLES(FRAME)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en),
        .rx_nib(rx_nib), .aln_nib(aln_nib), .frame_sync(frame_sync)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    fs_cnt  = 0;
    int    cyc     = 0;
    int    fill_ix = 0;
    bit    done    = 0;
    string req     = "R1";
    bit    q[$];

    // Reference model state.
    logic [63:0] m_hist = '0;
    int m_state = 0, m_off = 0, m_cnt = 0, m_miss = 0, m_fcnt = 0, m_pulse = 0;
    logic [3:0] exp_dout = '0;
    logic       exp_fs   = 1'b0;

    task automatic check(input string r, input int act, input int expv, input string what);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
        end
    endtask

    // Advance the model by one clock edge with inputs nib/en.
    task automatic model_edge(input logic [3:0] nib, input logic en);
        logic [3:0] mt;
        logic [3:0] nd;
        int lo;
        bit any, at_exp, hit, set;
        for (int i = 0; i < 4; i++) nd[i] = m_hist[m_off + 3 - i];
        for (int k = 0; k < 4; k++) mt[k] = ((m_hist >> k) & 64'hFFFF_FFFF) == 64'hF6F6_F628;
        any = |mt; lo = 0;
        for (int k = 3; k >= 0; k--) if (mt[k]) lo = k;
        at_exp = (m_fcnt == FRAME - 1);
        hit = mt[m_off];
        set = 0;
        if (en) begin
            if (m_state == 0) begin
                m_fcnt = 0;
                if (any) begin m_off = lo; m_cnt = 1; m_state = 1; end
            end else if (m_state == 1) begin
                if (at_exp && hit) begin
                    m_fcnt = 0;
                    if (m_cnt == 2) begin m_state = 2; m_miss = 0; m_cnt = 0; set = 1; end
                    else m_cnt++;
                end else if (any) begin
                    m_off = lo; m_cnt = 1; m_fcnt = 0;
                end else if (at_exp) begin
                    m_state = 0; m_cnt = 0; m_fcnt = 0;
                end else m_fcnt++;
            end else begin
                if (at_exp) begin
                    m_fcnt = 0;
                    if (hit) m_miss = 0;
                    else if (m_miss == 3) begin m_miss = 0; m_state = 0; end
                    else m_miss++;
                end else m_fcnt++;
            end
        end
        if (set) m_pulse = 4;
        else if (m_pulse > 0) m_pulse--;
        m_hist = {m_hist[59:0], nib[0], nib[1], nib[2], nib[3]};
        exp_dout = nd;
        exp_fs = (m_pulse != 0);
    endtask

    // One clock: compare outputs, drive new inputs, advance model.
    task automatic step(input logic [3:0] nib, input logic en);
        @(negedge clk);
        check(req, int'(aln_nib), int'(exp_dout), "aligned word");
        check(req, int'(frame_sync), int'(exp_fs), "frame_sync");
        if (frame_sync) fs_cnt++;
        rx_nib = nib;
        frame_en = en;
        model_edge(nib, en);
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) q.push_back(b[i]);
    endtask

    task automatic push_fill(input int n);
        for (int i = 0; i < n; i++) begin
            q.push_back((fill_ix % 3) == 0);
            fill_ix++;
        end
    endtask

    task automatic push_pat();
        push_byte(8'hF6); push_byte(8'hF6); push_byte(8'hF6); push_byte(8'h28);
    endtask

    // One 160-bit frame; la >= 0 places a payload copy la bits in.
    task automatic push_frame(input bit pat, input int la);
        if (pat) push_pat(); else push_fill(32);
        if (la >= 0) begin
            push_fill(la); push_pat(); push_fill(128 - 32 - la);
        end else push_fill(128);
    endtask

    task automatic run_q(input logic en);
        while (q.size() >= 4) begin
            logic [3:0] nb;
            for (int i = 0; i < 4; i++) nb[i] = q.pop_front();
            step(nb, en);
        end
    endtask

    // Watchdog: a hang counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1", int'(frame_sync), 0, "frame_sync in reset");
        check("R1", int'(aln_nib), 0, "aligned word in reset");
        rst_n = 1'b1;
        req = "R1";
        step(4'h0, 1'b1);

        // R2/R3/R4/R5: acquire at a one-bit offset.
        req = "R3";
        q.push_back(1'b0);
        push_frame(1, -1); push_frame(1, -1);
        run_q(1'b1);
        check("R5", fs_cnt, 0, "no sync before third word");
        req = "R2";
        fs_cnt = 0;
        push_frame(1, -1); push_frame(1, -1);
        run_q(1'b1);
        check("R5", fs_cnt, 4, "sync pulse length");

        // R7/R10: payload copies at other positions are ignored.
        req = "R7";
        fs_cnt = 0;
        push_frame(1, 10); push_frame(1, 41); push_frame(1, 7);
        run_q(1'b1);
        check("R7", fs_cnt, 0, "no pulse on payload copies");
        check("R10", int'(frame_sync), 0, "pulse not repeated in sync");

        // R8: a hit between misses clears the miss count.
        req = "R8";
        fs_cnt = 0;
        push_frame(0, -1); push_frame(0, -1); push_frame(0, -1);
        push_frame(1, -1);
        push_frame(0, -1); push_frame(0, -1); push_frame(0, -1);
        push_frame(1, -1);
        run_q(1'b1);
        check("R8", fs_cnt, 0, "miss count cleared by a hit");

        // R9: disabled search holds the offset through a two-bit slip.
        req = "R9";
        fs_cnt = 0;
        q.push_back(1'b1); q.push_back(1'b0);
        push_frame(1, -1); push_frame(1, -1); push_frame(1, -1); push_frame(1, -1);
        run_q(1'b0);
        check("R9", fs_cnt, 0, "no sync while disabled");

        // R8: re-enabled, misses drop to search, then reacquire.
        req = "R8";
        fs_cnt = 0;
        for (int f = 0; f < 9; f++) push_frame(1, -1);
        run_q(1'b1);
        check("R8", fs_cnt, 4, "reacquire after four misses");

        // R8: four empty frames leave sync.
        fs_cnt = 0;
        for (int f = 0; f < 5; f++) push_frame(0, -1);
        run_q(1'b1);
        check("R8", fs_cnt, 0, "no pulse while losing sync");

        // R6: a slip during confirmation restarts the count at one.
        req = "R6";
        fs_cnt = 0;
        q.push_back(1'b1);
        push_frame(1, -1);
        q.push_back(1'b0); q.push_back(1'b1);
        push_frame(1, -1); push_frame(1, -1);
        run_q(1'b1);
        check("R6", fs_cnt, 0, "restart after slip, two confirmed");
        push_frame(1, -1);
        run_q(1'b1);
        check("R6", fs_cnt, 4, "sync after restart plus two");

        // Drain.
        push_fill(64);
        run_q(1'b1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule